// File: doc/BRIEF.md
# Sticky Clear-on-Read Status Register Bank

This block holds a small bank of read-only status words that record link health events. Each bit watches one raw condition input. When its condition is seen at a clock edge, the bit captures the event and holds it until software reads the word. Each bit has one of two polarities, set per bit by a parameter mask. A latched-high bit rests at 0 and shows a captured event as 1. A latched-low bit rests at 1 and shows a captured event as 0. Both polarities can be mixed inside one word.

A read is a one-cycle strobe with a word address. The word as it stood in the read cycle is registered onto the data output. Every captured bit of that word then returns to its rest state. The exception is a bit whose condition is present at the read edge. That bit stays captured, so the event is not lost and a fault that is still active shows up again on the next read. Software cannot write the bank.

Top module: `sticky_status_bank`

## Requirements
- R1: After reset, every bit reads at its rest value. Bit i of word w takes its polarity from LL_MASK[w*WORD_W+i]: 1 selects latched-low, which rests at 1; 0 selects latched-high, which rests at 0.
- R2: A latched-high bit whose condition input is 1 at a clock edge reads 1 from then on until it is cleared.
- R3: A latched-low bit whose condition input is 1 at a clock edge reads 0 from then on until it is cleared.
- R4: When rd_en_i is 1 at a clock edge, rd_data_o shows the addressed word as it stood before that edge, starting one cycle later. The captured bits of that word return to rest after that edge.
- R5: A bit whose condition is still 1 at the read edge stays captured, so the next read of the word shows it again.
- R6: A condition that first appears at the same edge as a read of its word does not appear in that read's data. It stays captured and appears in the next read.
- R7: A read of an address at or above NUM_REGS returns 0 and clears no word.
- R8: A read clears only the addressed word. Captured bits in every other word are kept.
- R9: rd_data_o is 0 after reset and changes only at a read edge. Otherwise it holds its value.
- R10: While no read of its word occurs, a captured bit never returns to rest, however long its condition stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock; condition inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cond_i | input | NUM_REGS*WORD_W | Raw condition per bit; bit i of word w at index w*WORD_W+i; 1 means the event is present |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Word address of the read |
| rd_data_o | output | WORD_W | Registered read data, valid from the cycle after the strobe |

## Verification
Assertions check on every cycle that a present condition is captured at the next edge, that a captured bit is never lost without a clear, and that a clear without a condition returns the bit to rest. They also check that at most one word is cleared per cycle, that out-of-range reads return zero, and that the data output holds between reads. Other behaviours can only be shown by the bench's scenarios: the mixing of polarities within a word, the exact data a read returns relative to a same-edge event, the repeated report of an ongoing fault, and the fact that reads of one word leave the other words intact.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;

  // Capture polarity of one status bit.
  typedef enum logic {
    POL_LH = 1'b0,  // rests at 0, event shows as 1
    POL_LL = 1'b1   // rests at 1, event shows as 0
  } pol_e;

  function automatic pol_e pol_of(input logic mask_bit);
    return mask_bit ? POL_LL : POL_LH;
  endfunction

endpackage

// File: rtl/stsreg_rst_sync.sv
module stsreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/stsreg_cell.sv
module stsreg_cell
  import stsreg_pkg::*;
#(
  parameter pol_e POL = POL_LH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  output logic bit_o
);

  // err_q is 1 once an event is captured, whatever the polarity.
  logic err_q;
  logic err_d;
  logic err_en;

  always_comb begin
    err_en = cond_i | clr_i;
    // A present condition wins over the clear.
    err_d  = cond_i | (err_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  generate
    if (POL == POL_LL) begin : g_ll
      assign bit_o = ~err_q;
    end else begin : g_lh
      assign bit_o = err_q;
    end
  endgenerate

  // R2 / R3: a present condition is captured at the next edge.
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i |=> (bit_o == (POL == POL_LH)));

  // R10: a captured bit is kept until a clear arrives.
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bit_o == (POL == POL_LH)) && !clr_i) |=> (bit_o == (POL == POL_LH)));

  // R4: a clear without a condition returns the bit to rest.
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !cond_i) |=> (bit_o == (POL == POL_LL)));

endmodule

// File: rtl/stsreg_word.sv
module stsreg_word
  import stsreg_pkg::*;
#(
  parameter int          WORD_W  = 16,
  parameter logic [WORD_W-1:0] WORD_LL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cond_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] word_o
);

  generate
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam pol_e BIT_POL = pol_of(WORD_LL[b]);
      stsreg_cell #(.POL(BIT_POL)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .cond_i(cond_i[b]),
        .clr_i (clr_i),
        .bit_o (word_o[b])
      );
    end
  endgenerate

endmodule

// File: rtl/stsreg_read_port.sv
module stsreg_read_port #(
  parameter int NUM_REGS = 4,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  input  logic [NUM_REGS*WORD_W-1:0] words_i,
  output logic [NUM_REGS-1:0]        clr_o,
  output logic [WORD_W-1:0]          rd_data_o
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic              in_range;
  logic [WORD_W-1:0] sel_word;
  logic [WORD_W-1:0] rd_data_d;
  logic [WORD_W-1:0] rd_data_q;

  always_comb begin
    in_range = ({1'b0, rd_addr_i} < LIMIT);
    sel_word = '0;
    clr_o    = '0;
    for (int w = 0; w < NUM_REGS; w++) begin
      if (rd_addr_i == ADDR_W'(w)) begin
        sel_word = words_i[w*WORD_W +: WORD_W];
        clr_o[w] = rd_en_i;
      end
    end
    rd_data_d = in_range ? sel_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en_i) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data_o = rd_data_q;

  // R8: at most one word is cleared per cycle.
  p_one_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));

  // R7: an out-of-range read returns zero and clears nothing.
  p_oob_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !in_range) |=> (rd_data_o == '0));

  p_oob_noclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_range) |-> (clr_o == '0));

  // R9: data holds between reads.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/sticky_status_bank.sv
module sticky_status_bank #(
  parameter int NUM_REGS = 4,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 3,
  parameter logic [NUM_REGS*WORD_W-1:0] LL_MASK = 64'hA5A5_FFFF_0000_00FF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REGS*WORD_W-1:0] cond_i,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [WORD_W-1:0]          rd_data_o
);

  localparam int TOTAL_BITS = NUM_REGS * WORD_W;

  logic                  rst_n_sync;
  logic [TOTAL_BITS-1:0] words;
  logic [NUM_REGS-1:0]   clr;

  stsreg_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  generate
    for (genvar w = 0; w < NUM_REGS; w++) begin : g_word
      stsreg_word #(
        .WORD_W (WORD_W),
        .WORD_LL(LL_MASK[w*WORD_W +: WORD_W])
      ) u_word (
        .clk   (clk),
        .rst_n (rst_n_sync),
        .cond_i(cond_i[w*WORD_W +: WORD_W]),
        .clr_i (clr[w]),
        .word_o(words[w*WORD_W +: WORD_W])
      );
    end
  endgenerate

  stsreg_read_port #(
    .NUM_REGS(NUM_REGS),
    .WORD_W  (WORD_W),
    .ADDR_W  (ADDR_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .words_i  (words),
    .clr_o    (clr),
    .rd_data_o(rd_data_o)
  );

  // R1: the bank sits at its rest pattern while reset is held.
  p_rest_r1: assert property (@(posedge clk)
    !rst_n_sync |-> (words == LL_MASK));

endmodule

// File: tb/tb_sticky_status_bank.sv
module tb_sticky_status_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 4;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 3;
  localparam logic [63:0] LL_MASK = 64'hA5A5_FFFF_0000_00FF;

  // Vector: {addr, condition pulse, expected read data}
  localparam int NVEC = 6;
  localparam logic [34:0] VEC [NVEC] = '{
    {3'd0, 16'h0F0F, 16'h0FF0},  // R2 R3 mixed word
    {3'd1, 16'h8001, 16'h8001},  // R2 all latched-high
    {3'd2, 16'h00F0, 16'hFF0F},  // R3 all latched-low
    {3'd3, 16'hFFFF, 16'h5A5A},  // R2 R3 alternating
    {3'd0, 16'h0000, 16'h00FF},  // R4 rest after earlier clear
    {3'd3, 16'h0001, 16'hA5A4}   // R3 single low bit
  };

  logic               clk;
  logic               rst_n;
  logic [63:0]        cond;
  logic               rd_en;
  logic [ADDR_W-1:0]  rd_addr;
  logic [WORD_W-1:0]  rd_data;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  sticky_status_bank #(
    .NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LL_MASK(LL_MASK)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int w, input logic [15:0] pat);
    @(negedge clk);
    cond[w*16 +: 16] = pat;
    @(negedge clk);
    cond[w*16 +: 16] = 16'h0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en   = 1'b0;
    d       = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; cond = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: data output is zero after reset
    check("R9 reset data", rd_data, 16'h0000);
    // R1: rest pattern per word
    for (int w = 0; w < NUM_REGS; w++) begin
      do_read(ADDR_W'(w), d);
      check("R1 rest value", d, LL_MASK[w*16 +: 16]);
    end

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      pulse(int'(VEC[i][34:32]), VEC[i][31:16]);
      do_read(VEC[i][34:32], d);
      check("R2/R3 table capture", d, VEC[i][15:0]);
    end

    // R4: second read after clear shows rest
    pulse(1, 16'h0010);
    do_read(3'd1, d);
    check("R4 captured", d, 16'h0010);
    do_read(3'd1, d);
    check("R4 cleared", d, 16'h0000);

    // R5: ongoing condition survives clear
    @(negedge clk); cond[16 +: 16] = 16'h0002;
    @(negedge clk);
    do_read(3'd1, d);
    check("R5 first read", d, 16'h0002);
    do_read(3'd1, d);
    check("R5 ongoing read", d, 16'h0002);
    cond[16 +: 16] = 16'h0000;
    do_read(3'd1, d);
    check("R5 last capture", d, 16'h0002);
    do_read(3'd1, d);
    check("R5 gone", d, 16'h0000);

    // R6: event at the read edge
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd0; cond[15:0] = 16'h0100;
    @(negedge clk);
    rd_en = 1'b0; cond[15:0] = 16'h0000;
    check("R6 same-edge read", rd_data, 16'h00FF);
    do_read(3'd0, d);
    check("R6 event kept", d, 16'h01FF);

    // R7: out of range
    pulse(1, 16'h0400);
    do_read(3'd5, d);
    check("R7 oob data", d, 16'h0000);
    do_read(3'd1, d);
    check("R7 no clear", d, 16'h0400);

    // R8: only addressed word cleared
    @(negedge clk); cond[15:0] = 16'h0001; cond[48 +: 16] = 16'h0100;
    @(negedge clk); cond = '0;
    do_read(3'd0, d);
    check("R8 word0", d, 16'h00FE);
    do_read(3'd3, d);
    check("R8 word3 kept", d, 16'hA4A5);

    // R9: hold between reads while events arrive
    pulse(2, 16'h8000);
    repeat (5) @(negedge clk);
    check("R9 hold", rd_data, 16'hA4A5);

    // R10: sticky over many idle cycles
    pulse(2, 16'h0001);
    repeat (10) @(negedge clk);
    do_read(3'd2, d);
    check("R10 sticky", d, 16'h7FFE);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule